// File: doc/BRIEF.md
# Dual Saturating Unsigned Halfword Multiplier

This block is a two-lane multiply unit with its own file of eight 32-bit registers. One operation names a single destination register and, for each of the two result lanes, two source registers together with an upper/lower half choice per source. Both lanes form a 16x16 unsigned integer product at the same time. A product that does not fit in 16 bits is clamped to 0xFFFF. The high-lane result goes to bits 31:16 of the destination and the low-lane result goes to bits 15:0, both in the same clock edge.

Registers are filled through a load port and inspected through a combinational read-back port. An operation is issued with a one-cycle `issue` strobe. A registered overflow pulse reports whether either lane clamped. Reset is asserted asynchronously and active low, and its release is synchronised inside the block.

Top module: `dsm_unit`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads 0x00000000 and `ovf` is low.
- R2: A load with `ld_en` high writes all 32 bits of `ld_data` into register `ld_idx` at the next clock edge. The new value is then visible on `rd_data` when `rd_idx` selects it.
- R3: Both operands are unsigned 16-bit integers and no fractional shift is applied. A product of at most 0xFFFF is written unchanged, for example 0x3004*0x0004=0xC010 and 0x0007*0x0D09=0x5B3F.
- R4: A product greater than 0xFFFF is written as 0xFFFF, for example 0x3004*0x3004 and 0x0735*0x0024.
- R5: The operation word is laid out as follows. Bits [2:0] hold the destination index, bits [10:3] select the low lane and bits [18:11] select the high lane. Inside each 8-bit lane field, [2:0] is the first source index and [3] is its half, while [6:4] is the second source index and [7] is its half. A half bit of 1 takes bits 31:16 and 0 takes bits 15:0, chosen independently for all four operands.
- R6: One issue writes the high-lane result to destination bits 31:16 and the low-lane result to bits 15:0 at the next edge. No other register changes.
- R7: All four operands use register values from before the operation, including when the destination is also a source.
- R8: If a load and an issued operation target the same register in the same cycle, the product is stored. A load to a different register in that cycle still takes effect.
- R9: `ovf` is high for exactly the cycle after an issue in which at least one lane clamped. It is low after any other cycle.
- R10: While `issue` and `ld_en` are low, `op_word` is ignored and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_en | input | 1 | Load strobe |
| ld_idx | input | 3 | Register written by a load |
| ld_data | input | 32 | Value written by a load |
| issue | input | 1 | Start one dual multiply with `op_word` |
| op_word | input | 19 | Destination and lane operand selection |
| rd_idx | input | 3 | Register shown on `rd_data` |
| rd_data | output | 32 | Current value of register `rd_idx` |
| ovf | output | 1 | One-cycle pulse: a lane of the last operation clamped |

## Verification
The main sweep uses every destination. For each one it walks all source-index and half-select combinations of the high lane, and derives the low lane from them in a different arrangement, so a swapped field or a wrong half shows up as a wrong word. The register values come from a pool that includes 0xFFFF*1 and 0x00FF*0x0101, which land exactly on 0xFFFF without clamping, and 0x0100*0x0100, which just exceeds it. These values separate a wrong clamp threshold from a correct one and a dropped overflow pulse from a spurious one. Separate directed cases check a destination that is also its own source, a load colliding with a multiply on the same register and on a different register, and op words that change while `issue` is low.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int DSM_NUM_REGS = 8;
  localparam int DSM_REG_W    = 32;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;
endpackage

// File: rtl/dsm_rst_sync.sv
module dsm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/dsm_regfile.sv
module dsm_regfile #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ld_en,
  input  logic [IDX_W-1:0]               ld_idx,
  input  logic [REG_W-1:0]               ld_data,
  input  logic                           mul_en,
  input  logic [IDX_W-1:0]               mul_idx,
  input  logic [REG_W-1:0]               mul_data,
  output logic [NUM_REGS-1:0][REG_W-1:0] regs_q
);
  logic [REG_W-1:0] store_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic             ld_hit;
    logic             mul_hit;
    logic             reg_en;
    logic [REG_W-1:0] reg_d;

    // next-state: the multiply write outranks a load to the same register
    always_comb begin
      ld_hit  = ld_en  && (ld_idx  == IDX_W'(g));
      mul_hit = mul_en && (mul_idx == IDX_W'(g));
      reg_en  = ld_hit || mul_hit;
      reg_d   = mul_hit ? mul_data : ld_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      store_q[g] <= '0;
      else if (reg_en) store_q[g] <= reg_d;
    end

    assign regs_q[g] = store_q[g];
  end
endmodule

// File: rtl/dsm_half_pick.sv
module dsm_half_pick
  import dsm_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 32,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter int HALF_W   = REG_W / 2
) (
  input  logic [NUM_REGS-1:0][REG_W-1:0] regs,
  input  logic [IDX_W-1:0]               idx,
  input  half_sel_e                      sel,
  output logic [HALF_W-1:0]              half
);
  logic [REG_W-1:0] word;

  always_comb begin
    word = regs[idx];
    if (sel == HALF_HI) half = word[REG_W-1 -: HALF_W];
    else                half = word[HALF_W-1:0];
  end
endmodule

// File: rtl/dsm_sat_lane.sv
module dsm_sat_lane #(
  parameter int HALF_W = 16
) (
  input  logic [HALF_W-1:0] op_a,
  input  logic [HALF_W-1:0] op_b,
  output logic [HALF_W-1:0] res,
  output logic              sat
);
  localparam int PROD_W = 2 * HALF_W;

  logic [PROD_W-1:0] prod;

  always_comb begin
    prod = PROD_W'(op_a) * PROD_W'(op_b);
    sat  = |prod[PROD_W-1:HALF_W];
    res  = sat ? {HALF_W{1'b1}} : prod[HALF_W-1:0];
  end
endmodule

// File: rtl/dsm_unit.sv
module dsm_unit
  import dsm_pkg::*;
#(
  parameter int NUM_REGS = DSM_NUM_REGS,
  parameter int REG_W    = DSM_REG_W,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter int OP_W     = IDX_W + 4 * (IDX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [REG_W-1:0] ld_data,
  input  logic             issue,
  input  logic [OP_W-1:0]  op_word,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [REG_W-1:0] rd_data,
  output logic             ovf
);
  localparam int HALF_W = REG_W / 2;
  localparam int SRC_W  = IDX_W + 1;
  localparam int LANE_W = 2 * SRC_W;
  localparam int LANES  = 2;

  logic                           rst_q_n;
  logic [NUM_REGS-1:0][REG_W-1:0] regs_q;
  logic [IDX_W-1:0]               dest_idx;
  logic [LANES-1:0][HALF_W-1:0]   lane_res;
  logic [LANES-1:0]               lane_sat;
  logic [REG_W-1:0]               mul_data;
  logic                           ovf_d;
  logic                           ovf_q;

  dsm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  assign dest_idx = op_word[IDX_W-1:0];

  // lane 1 feeds the upper half of the destination, lane 0 the lower half
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [1:0][HALF_W-1:0] opnd;
    logic [LANE_W-1:0]      lane_fld;

    assign lane_fld = op_word[IDX_W + l*LANE_W +: LANE_W];

    for (genvar k = 0; k < 2; k++) begin : g_src
      logic [IDX_W-1:0] src_idx;
      half_sel_e        src_sel;

      assign src_idx = lane_fld[k*SRC_W +: IDX_W];
      assign src_sel = half_sel_e'(lane_fld[k*SRC_W + IDX_W]);

      dsm_half_pick #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .IDX_W    (IDX_W),
        .HALF_W   (HALF_W)
      ) u_pick (
        .regs (regs_q),
        .idx  (src_idx),
        .sel  (src_sel),
        .half (opnd[k])
      );
    end

    dsm_sat_lane #(.HALF_W(HALF_W)) u_lane (
      .op_a (opnd[0]),
      .op_b (opnd[1]),
      .res  (lane_res[l]),
      .sat  (lane_sat[l])
    );
  end

  assign mul_data = {lane_res[1], lane_res[0]};

  dsm_regfile #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .IDX_W    (IDX_W)
  ) u_regfile (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .ld_en    (ld_en),
    .ld_idx   (ld_idx),
    .ld_data  (ld_data),
    .mul_en   (issue),
    .mul_idx  (dest_idx),
    .mul_data (mul_data),
    .regs_q   (regs_q)
  );

  always_comb begin
    ovf_d = issue && (|lane_sat);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) ovf_q <= 1'b0;
    else          ovf_q <= ovf_d;
  end

  assign ovf     = ovf_q;
  assign rd_data = regs_q[rd_idx];
endmodule

// File: rtl/dsm_unit_chk.sv
module dsm_unit_chk #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 32,
  parameter int IDX_W    = $clog2(NUM_REGS),
  parameter int OP_W     = IDX_W + 4 * (IDX_W + 1)
) (
  input logic                           clk,
  input logic                           rst_q_n,
  input logic                           ld_en,
  input logic [IDX_W-1:0]               ld_idx,
  input logic [REG_W-1:0]               ld_data,
  input logic                           issue,
  input logic [OP_W-1:0]                op_word,
  input logic                           ovf,
  input logic [NUM_REGS-1:0][REG_W-1:0] regs_q
);
  localparam int HALF_W = REG_W / 2;
  localparam int SRC_W  = IDX_W + 1;
  localparam int LANE_W = 2 * SRC_W;

  function automatic logic [HALF_W-1:0] take(input logic [NUM_REGS-1:0][REG_W-1:0] r,
                                             input logic [SRC_W-1:0] s);
    logic [REG_W-1:0] w;
    w = r[s[IDX_W-1:0]];
    return s[IDX_W] ? w[REG_W-1:HALF_W] : w[HALF_W-1:0];
  endfunction

  function automatic logic [2*HALF_W:0] lane_ref(input logic [NUM_REGS-1:0][REG_W-1:0] r,
                                                 input logic [LANE_W-1:0] f);
    logic [2*HALF_W-1:0] p;
    p = (2*HALF_W)'(take(r, f[SRC_W-1:0])) * (2*HALF_W)'(take(r, f[LANE_W-1:SRC_W]));
    if (p > (2*HALF_W)'({HALF_W{1'b1}})) return {1'b1, {HALF_W{1'b0}}, {HALF_W{1'b1}}};
    return {1'b0, p};
  endfunction

  logic [2*HALF_W:0] ref_hi;
  logic [2*HALF_W:0] ref_lo;
  logic [REG_W-1:0]  ref_word;
  logic              ref_ovf;
  logic [IDX_W-1:0]  dest;

  always_comb begin
    dest     = op_word[IDX_W-1:0];
    ref_lo   = lane_ref(regs_q, op_word[IDX_W +: LANE_W]);
    ref_hi   = lane_ref(regs_q, op_word[IDX_W + LANE_W +: LANE_W]);
    ref_word = {ref_hi[HALF_W-1:0], ref_lo[HALF_W-1:0]};
    ref_ovf  = ref_hi[2*HALF_W] || ref_lo[2*HALF_W];
  end

  // R3 R4 R5 R7
  product_word_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    issue |=> regs_q[$past(dest)] == $past(ref_word));

  // R9
  ovf_on_issue_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    issue |=> ovf == $past(ref_ovf));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !issue |=> !ovf);

  // R2
  load_write_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ld_en && !(issue && ld_idx == dest)) |=> regs_q[$past(ld_idx)] == $past(ld_data));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!issue && !ld_en) |=> $stable(regs_q));

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_other
    // R6
    other_reg_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      (issue && dest != IDX_W'(g) && !(ld_en && ld_idx == IDX_W'(g))) |=> $stable(regs_q[g]));
  end
endmodule

bind dsm_unit dsm_unit_chk #(
  .NUM_REGS (NUM_REGS),
  .REG_W    (REG_W),
  .IDX_W    (IDX_W),
  .OP_W     (OP_W)
) u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .ld_en   (ld_en),
  .ld_idx  (ld_idx),
  .ld_data (ld_data),
  .issue   (issue),
  .op_word (op_word),
  .ovf     (ovf),
  .regs_q  (regs_q)
);

// File: tb/dsm_unit_bench.sv
module dsm_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        ld_en;
  logic [2:0]  ld_idx;
  logic [31:0] ld_data;
  logic        issue;
  logic [18:0] op_word;
  logic [2:0]  rd_idx;
  logic [31:0] rd_data;
  logic        ovf;

  int nchk;
  int nerr;
  logic [31:0] mdl [8];

  dsm_unit u_dsm_unit (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_en),
    .ld_idx  (ld_idx),
    .ld_data (ld_data),
    .issue   (issue),
    .op_word (op_word),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .ovf     (ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired before the run completed");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pool(input int k);
    case (k % 16)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;  3: return 16'h0004;
      4: return 16'h00FF;  5: return 16'h0100;  6: return 16'h0101;  7: return 16'h3004;
      8: return 16'h0735;  9: return 16'h0024; 10: return 16'h0007; 11: return 16'h0D09;
      12: return 16'hFFFF; 13: return 16'h8000; 14: return 16'h0003; default: return 16'h5555;
    endcase
  endfunction

  function automatic logic [7:0] lsel(input int ai, input int ah, input int bi, input int bh);
    return {bh[0], bi[2:0], ah[0], ai[2:0]};
  endfunction

  function automatic logic [15:0] pick(input logic [3:0] s);
    return s[3] ? mdl[s[2:0]][31:16] : mdl[s[2:0]][15:0];
  endfunction

  function automatic logic [16:0] mul_ref(input logic [7:0] f);
    logic [31:0] p;
    p = {16'h0, pick(f[3:0])} * {16'h0, pick(f[7:4])};
    if (p > 32'h0000FFFF) return {1'b1, 16'hFFFF};
    return {1'b0, p[15:0]};
  endfunction

  task automatic load(input int idx, input logic [31:0] val);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = idx[2:0]; ld_data = val;
    @(negedge clk);
    ld_en = 1'b0;
    mdl[idx] = val;
  endtask

  task automatic do_op(input string tag, input int dest, input logic [7:0] hs,
                       input logic [7:0] ls, input logic [31:0] exp_w, input logic exp_o);
    @(negedge clk);
    issue = 1'b1; op_word = {hs, ls, dest[2:0]};
    @(negedge clk);
    issue = 1'b0; rd_idx = dest[2:0];
    #1;
    check(tag, rd_data, exp_w);
    check({tag, " R9 ovf"}, {31'h0, ovf}, {31'h0, exp_o});
    mdl[dest] = exp_w;
  endtask

  task automatic model_op(input string tag, input int dest, input logic [7:0] hs, input logic [7:0] ls);
    logic [16:0] h;
    logic [16:0] l;
    h = mul_ref(hs);
    l = mul_ref(ls);
    do_op(tag, dest, hs, ls, {h[15:0], l[15:0]}, h[16] | l[16]);
  endtask

  task automatic read_all(input string tag);
    for (int i = 0; i < 8; i++) begin
      rd_idx = i[2:0];
      #1;
      check(tag, rd_data, mdl[i]);
    end
  endtask

  initial begin
    nchk = 0; nerr = 0;
    rst_n = 1'b0; ld_en = 1'b0; ld_idx = '0; ld_data = '0;
    issue = 1'b0; op_word = '0; rd_idx = '0;
    for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
    repeat (3) @(negedge clk);
    read_all("R1 reg in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_all("R1 reg after reset");
    check("R1 ovf after reset", {31'h0, ovf}, 32'h0);

    // R2 load visible on read-back
    load(3, 32'hDEAD_BEEF);
    rd_idx = 3'd3; #1;
    check("R2 load", rd_data, 32'hDEAD_BEEF);

    // R3 R4 worked examples
    load(0, 32'h3004_0004);
    load(1, 32'h0735_0024);
    do_op("R4 3004*3004", 4, lsel(0,1,0,1), lsel(0,1,0,0), 32'hFFFF_C010, 1'b1);
    do_op("R4 0735*0024", 5, lsel(1,1,1,0), lsel(1,0,1,0), 32'hFFFF_0510, 1'b1);
    load(2, 32'h0007_0D09);
    do_op("R3 0007*0D09", 6, lsel(2,1,2,0), lsel(2,1,2,1), 32'h5B3F_0031, 1'b0);
    // R3 exact ceiling without clamp, R4 just above it
    load(2, 32'hFFFF_0001);
    load(3, 32'h00FF_0101);
    do_op("R3 FFFF*0001 and 00FF*0101", 7, lsel(2,1,2,0), lsel(3,1,3,0), 32'hFFFF_FFFF, 1'b0);
    load(3, 32'h0100_0100);
    do_op("R4 0100*0100", 7, lsel(3,1,3,0), lsel(3,0,2,0), 32'hFFFF_0100, 1'b1);

    // R7 destination read as source in both lanes
    load(2, 32'h0003_0005);
    do_op("R7 self source", 2, lsel(2,1,2,0), lsel(2,0,2,0), 32'h000F_0019, 1'b0);

    // R8 load collides with multiply on the same register
    load(5, 32'h0002_0003);
    @(negedge clk);
    issue = 1'b1; op_word = {lsel(5,1,5,0), lsel(5,0,5,0), 3'd5};
    ld_en = 1'b1; ld_idx = 3'd5; ld_data = 32'hAAAA_5555;
    @(negedge clk);
    issue = 1'b0; ld_en = 1'b0; rd_idx = 3'd5; #1;
    check("R8 multiply wins", rd_data, 32'h0006_0009);
    mdl[5] = 32'h0006_0009;
    // R8 load to another register in the same cycle
    @(negedge clk);
    issue = 1'b1; op_word = {lsel(5,1,5,1), lsel(5,0,5,1), 3'd4};
    ld_en = 1'b1; ld_idx = 3'd6; ld_data = 32'h1234_5678;
    @(negedge clk);
    issue = 1'b0; ld_en = 1'b0; rd_idx = 3'd4; #1;
    check("R8 product stored", rd_data, 32'h0024_0036);
    rd_idx = 3'd6; #1;
    check("R8 side load", rd_data, 32'h1234_5678);
    mdl[4] = 32'h0024_0036; mdl[6] = 32'h1234_5678;

    // R10 op_word without issue
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      op_word = 19'(32'h5A5A3 * (c + 7));
    end
    @(negedge clk);
    read_all("R10 idle hold");
    check("R10 R9 ovf idle", {31'h0, ovf}, 32'h0);

    // R5 R6 sweep: every destination, all high-lane field combinations
    for (int d = 0; d < 8; d++) begin
      for (int r = 0; r < 8; r++) load(r, {pool(2*r + d), pool(2*r + 1 + 3*d)});
      for (int ai = 0; ai < 8; ai++)
        for (int ah = 0; ah < 2; ah++)
          for (int bi = 0; bi < 8; bi++)
            for (int bh = 0; bh < 2; bh++)
              model_op("R5 R6 sweep", d, lsel(ai, ah, bi, bh),
                       lsel(bi, 1 - bh, (ai + 1) % 8, ah));
      @(negedge clk);
      read_all("R6 others untouched");
    end

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 8; i++) mdl[i] = 32'h0;
    #1;
    read_all("R1 async clear");
    check("R1 ovf in reset", {31'h0, ovf}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule